// File: doc/BRIEF.md
# Dual-Plane Glyph Register Store

This block keeps the character codes for a small bank of display digits in two parallel storage planes. A register-port bus writes one plane, the other plane, or both planes of a digit with a single access. A combinational read port returns the stored value of any single-plane address. The mirrored both-plane addresses and every unmapped address read back as zero.

A display scanner presents the index of the digit it is refreshing. The block returns a 7-bit character index for the font lookup, plus an invert flag. The font stage applies the invert flag to the column pattern after the lookup. The plane shown is plane 0 whenever blinking is off. When blinking is on, the plane follows the blink phase.

A clear request sets every digit in both planes back to the blank code. Reset does the same.

Top module: `glyph_plane_store`

## Requirements
- R1: While reset is held and after it is released, all eight stored codes equal 0x20 (blank). Reading 0x20–0x23 and 0x40–0x43 returns 0x20, and the scan output is index 0x20 with invert low.
- R2: A write to address 0x20+d (d = 0..3) loads plane 0 of digit d at the clock edge. From the next cycle, reading 0x20+d returns the written byte and plane 1 is unchanged.
- R3: A write to address 0x40+d loads plane 1 of digit d at the clock edge. From the next cycle, reading 0x40+d returns the written byte and plane 0 is unchanged.
- R4: A write to address 0x60+d loads the same byte into both planes of digit d. Reads of 0x60–0x63 always return 0x00.
- R5: A write to any 8-bit address outside 0x20–0x23, 0x40–0x43 and 0x60–0x63 changes no stored code. Reads of such addresses return 0x00. Addresses are decoded on all eight bits.
- R6: With blink_en low, the scan output comes from plane 0 of scan_digit whatever the value of blink_phase.
- R7: With blink_en high, the scan output comes from plane 0 when blink_phase is 0 and from plane 1 when blink_phase is 1.
- R8: glyph_idx equals bits 6:0 of the selected code, and glyph_inv equals bit 7.
- R9: clear_req high at a clock edge sets all eight codes to 0x20 from the next cycle. A write in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| scan_digit | input | 2 | Digit currently being refreshed |
| blink_en | input | 1 | Blink enable |
| blink_phase | input | 1 | Current blink phase, 0 = plane 0 |
| clear_req | input | 1 | Return all codes to blank |
| glyph_idx | output | 7 | Character index for the font lookup |
| glyph_inv | output | 1 | Invert the looked-up column pattern |

## Verification
The hardest case to reach is a write aimed at the mirrored or an unmapped address, because its effect, or lack of one, does not show at the written address. A both-plane address always reads zero, and an unmapped write changes nothing visible there. The bench therefore sweeps every 8-bit write address with a distinct data byte. After each write it reads all eight storage addresses back and compares them with a model, so a stray or missing update shows up in the plane it actually touched. A clear issued together with a write confirms that the clear takes priority.

// File: rtl/glyph_store_pkg.sv
package glyph_store_pkg;
    localparam logic [7:0] BLANK_CODE = 8'h20;

    typedef enum logic {
        PLANE_0 = 1'b0,
        PLANE_1 = 1'b1
    } plane_sel_e;
endpackage

// File: rtl/glyph_addr_decode.sv
module glyph_addr_decode #(
    parameter int ADDR_W     = 8,
    parameter int NUM_DIGITS = 4,
    parameter int P0_BASE    = 'h20,
    parameter int P1_BASE    = 'h40,
    parameter int BOTH_BASE  = 'h60,
    localparam int DIG_W     = $clog2(NUM_DIGITS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_p0,
    output logic              hit_p1,
    output logic              hit_both,
    output logic [DIG_W-1:0]  digit
);
    localparam logic [ADDR_W-1:0] P0_LO = ADDR_W'(P0_BASE);
    localparam logic [ADDR_W-1:0] P1_LO = ADDR_W'(P1_BASE);
    localparam logic [ADDR_W-1:0] BO_LO = ADDR_W'(BOTH_BASE);
    localparam logic [ADDR_W-1:0] SPAN  = ADDR_W'(NUM_DIGITS);

    // Bases are aligned to NUM_DIGITS, so the low bits give the digit.
    always_comb begin
        hit_p0   = (addr >= P0_LO) && (addr < P0_LO + SPAN);
        hit_p1   = (addr >= P1_LO) && (addr < P1_LO + SPAN);
        hit_both = (addr >= BO_LO) && (addr < BO_LO + SPAN);
        digit    = addr[DIG_W-1:0];
    end
endmodule

// File: rtl/glyph_plane_bank.sv
module glyph_plane_bank
    import glyph_store_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int DATA_W     = 8,
    localparam int DIG_W     = $clog2(NUM_DIGITS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         we,
    input  logic [DIG_W-1:0]             wdig,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_DIGITS*DATA_W-1:0] codes
);
    localparam logic [DATA_W-1:0] BLANK_V = DATA_W'(BLANK_CODE);

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                codes[g*DATA_W +: DATA_W] <= BLANK_V;
            end else if (clr) begin
                codes[g*DATA_W +: DATA_W] <= BLANK_V;
            end else if (we && (wdig == DIG_W'(g))) begin
                codes[g*DATA_W +: DATA_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/glyph_plane_mux.sv
module glyph_plane_mux
    import glyph_store_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int DATA_W     = 8,
    localparam int DIG_W     = $clog2(NUM_DIGITS)
) (
    input  logic [NUM_DIGITS*DATA_W-1:0] p0_codes,
    input  logic [NUM_DIGITS*DATA_W-1:0] p1_codes,
    input  logic [DIG_W-1:0]             digit,
    input  logic                         blink_en,
    input  logic                         blink_phase,
    output logic [DATA_W-2:0]            idx,
    output logic                         inv
);
    plane_sel_e          sel;
    logic [DATA_W-1:0]   code;

    always_comb begin
        sel = (blink_en && blink_phase) ? PLANE_1 : PLANE_0;
        unique case (sel)
            PLANE_0: code = p0_codes[digit*DATA_W +: DATA_W];
            PLANE_1: code = p1_codes[digit*DATA_W +: DATA_W];
            default: code = p0_codes[digit*DATA_W +: DATA_W];
        endcase
        idx = code[DATA_W-2:0];
        inv = code[DATA_W-1];
    end
endmodule

// File: rtl/glyph_plane_store.sv
module glyph_plane_store #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int NUM_DIGITS = 4,
    parameter int P0_BASE    = 'h20,
    parameter int P1_BASE    = 'h40,
    parameter int BOTH_BASE  = 'h60,
    localparam int DIG_W     = $clog2(NUM_DIGITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DIG_W-1:0]  scan_digit,
    input  logic              blink_en,
    input  logic              blink_phase,
    input  logic              clear_req,
    output logic [DATA_W-2:0] glyph_idx,
    output logic              glyph_inv
);
    logic                         w_p0, w_p1, w_both;
    logic [DIG_W-1:0]             w_dig;
    logic                         r_p0, r_p1, r_both;
    logic [DIG_W-1:0]             r_dig;
    logic [NUM_DIGITS*DATA_W-1:0] p0_flat, p1_flat;

    glyph_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_DIGITS(NUM_DIGITS),
        .P0_BASE(P0_BASE), .P1_BASE(P1_BASE), .BOTH_BASE(BOTH_BASE)
    ) wdec_i (
        .addr(wr_addr), .hit_p0(w_p0), .hit_p1(w_p1),
        .hit_both(w_both), .digit(w_dig)
    );

    glyph_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_DIGITS(NUM_DIGITS),
        .P0_BASE(P0_BASE), .P1_BASE(P1_BASE), .BOTH_BASE(BOTH_BASE)
    ) rdec_i (
        .addr(rd_addr), .hit_p0(r_p0), .hit_p1(r_p1),
        .hit_both(r_both), .digit(r_dig)
    );

    glyph_plane_bank #(.NUM_DIGITS(NUM_DIGITS), .DATA_W(DATA_W)) bank0_i (
        .clk(clk), .rst_n(rst_n), .clr(clear_req),
        .we(wr_en && (w_p0 || w_both)), .wdig(w_dig), .wdata(wr_data),
        .codes(p0_flat)
    );

    glyph_plane_bank #(.NUM_DIGITS(NUM_DIGITS), .DATA_W(DATA_W)) bank1_i (
        .clk(clk), .rst_n(rst_n), .clr(clear_req),
        .we(wr_en && (w_p1 || w_both)), .wdig(w_dig), .wdata(wr_data),
        .codes(p1_flat)
    );

    glyph_plane_mux #(.NUM_DIGITS(NUM_DIGITS), .DATA_W(DATA_W)) mux_i (
        .p0_codes(p0_flat), .p1_codes(p1_flat), .digit(scan_digit),
        .blink_en(blink_en), .blink_phase(blink_phase),
        .idx(glyph_idx), .inv(glyph_inv)
    );

    // Mirrored and unmapped addresses read as zero.
    always_comb begin
        if (r_p0) begin
            rd_data = p0_flat[r_dig*DATA_W +: DATA_W];
        end else if (r_p1) begin
            rd_data = p1_flat[r_dig*DATA_W +: DATA_W];
        end else if (r_both) begin
            rd_data = '0;
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/glyph_plane_store_chk.sv
module glyph_plane_store_chk #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int NUM_DIGITS = 4,
    parameter int P0_BASE    = 'h20,
    parameter int P1_BASE    = 'h40,
    parameter int BOTH_BASE  = 'h60,
    localparam int DIG_W     = $clog2(NUM_DIGITS)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [DATA_W-1:0]            wr_data,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic [DATA_W-1:0]            rd_data,
    input logic [DIG_W-1:0]             scan_digit,
    input logic                         blink_en,
    input logic                         blink_phase,
    input logic                         clear_req,
    input logic [DATA_W-2:0]            glyph_idx,
    input logic                         glyph_inv,
    input logic [NUM_DIGITS*DATA_W-1:0] p0_flat,
    input logic [NUM_DIGITS*DATA_W-1:0] p1_flat
);
    localparam logic [ADDR_W-1:0] P0_LO = ADDR_W'(P0_BASE);
    localparam logic [ADDR_W-1:0] P1_LO = ADDR_W'(P1_BASE);
    localparam logic [ADDR_W-1:0] BO_LO = ADDR_W'(BOTH_BASE);
    localparam logic [ADDR_W-1:0] SPAN  = ADDR_W'(NUM_DIGITS);

    logic in_p0, in_p1, in_bo;
    logic [DIG_W-1:0] last_dig;

    assign in_p0 = (wr_addr >= P0_LO) && (wr_addr < P0_LO + SPAN);
    assign in_p1 = (wr_addr >= P1_LO) && (wr_addr < P1_LO + SPAN);
    assign in_bo = (wr_addr >= BO_LO) && (wr_addr < BO_LO + SPAN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_dig <= '0;
        else        last_dig <= wr_addr[DIG_W-1:0];
    end

    AST_MIRROR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr >= BO_LO) && (rd_addr < BO_LO + SPAN)) |-> (rd_data == '0)); // R4

    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear_req && !in_p0 && !in_p1 && !in_bo)
        |=> ($stable(p0_flat) && $stable(p1_flat))); // R5

    AST_P0_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear_req && in_p0)
        |=> (p0_flat[last_dig*DATA_W +: DATA_W] == $past(wr_data))); // R2

    AST_BLINK_OFF_P0: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |-> ({glyph_inv, glyph_idx} == p0_flat[scan_digit*DATA_W +: DATA_W])); // R6

    AST_PHASE_ONE_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && blink_phase)
        |-> ({glyph_inv, glyph_idx} == p1_flat[scan_digit*DATA_W +: DATA_W])); // R7

    AST_CLEAR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> ((p0_flat == {NUM_DIGITS{8'h20}}) && (p1_flat == {NUM_DIGITS{8'h20}}))); // R9
endmodule

bind glyph_plane_store glyph_plane_store_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DIGITS(NUM_DIGITS),
    .P0_BASE(P0_BASE), .P1_BASE(P1_BASE), .BOTH_BASE(BOTH_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .scan_digit(scan_digit), .blink_en(blink_en), .blink_phase(blink_phase),
    .clear_req(clear_req), .glyph_idx(glyph_idx), .glyph_inv(glyph_inv),
    .p0_flat(p0_flat), .p1_flat(p1_flat)
);

// File: tb/glyph_plane_store_tb.sv
module glyph_plane_store_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] scan_digit = '0;
    logic       blink_en = 1'b0;
    logic       blink_phase = 1'b0;
    logic       clear_req = 1'b0;
    logic [6:0] glyph_idx;
    logic       glyph_inv;

    int errors = 0;
    int checks = 0;
    logic [7:0] m0 [4];
    logic [7:0] m1 [4];

    always #4 clk = ~clk;

    glyph_plane_store dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .scan_digit(scan_digit), .blink_en(blink_en), .blink_phase(blink_phase),
        .clear_req(clear_req), .glyph_idx(glyph_idx), .glyph_inv(glyph_inv)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a >= 8'h20 && a <= 8'h23) return m0[a[1:0]];
        if (a >= 8'h40 && a <= 8'h43) return m1[a[1:0]];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [7:0] a);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp_read(a));
    endtask

    task automatic glyph_chk(input string req, input int d, input logic be, input logic ph);
        logic [7:0] src;
        scan_digit = d[1:0];
        blink_en = be;
        blink_phase = ph;
        #1;
        src = (be && ph) ? m1[d] : m0[d];
        chk({req, " idx"}, {1'b0, glyph_idx}, {1'b0, src[6:0]});
        chk({req, " inv"}, {7'b0, glyph_inv}, {7'b0, src[7]});
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a >= 8'h20 && a <= 8'h23) m0[a[1:0]] = d;
        if (a >= 8'h40 && a <= 8'h43) m1[a[1:0]] = d;
        if (a >= 8'h60 && a <= 8'h63) begin
            m0[a[1:0]] = d;
            m1[a[1:0]] = d;
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_all_storage(input string req);
        for (int k = 0; k < 4; k++) begin
            read_chk(req, 8'h20 + 8'(k));
            read_chk(req, 8'h40 + 8'(k));
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            m0[k] = 8'h20;
            m1[k] = 8'h20;
        end
        // R1: values held during reset
        repeat (3) @(negedge clk);
        check_all_storage("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all_storage("R1 after reset");
        for (int d = 0; d < 4; d++) glyph_chk("R1 scan", d, 1'b0, 1'b0);
        // R5: every non-storage address reads zero
        for (int a = 0; a < 256; a++) begin
            if (!((a >= 'h20 && a <= 'h23) || (a >= 'h40 && a <= 'h43)))
                read_chk("R5 R4 zero read", 8'(a));
        end

        // R2 R3 R4 R5: sweep every write address
        for (int a = 0; a < 256; a++) begin
            logic [7:0] dv;
            string tag;
            dv = 8'((a * 37 + 11) & 'hFF);
            if (dv == 8'h20) dv = 8'h5A;
            if (a >= 'h20 && a <= 'h23)      tag = "R2 plane0 write";
            else if (a >= 'h40 && a <= 'h43) tag = "R3 plane1 write";
            else if (a >= 'h60 && a <= 'h63) tag = "R4 both-plane write";
            else                             tag = "R5 unmapped write";
            do_write(8'(a), dv);
            #1;
            check_all_storage(tag);
            read_chk(tag, 8'(a));
        end

        // R6 R7 R8: distinct codes with mixed invert bits
        for (int d = 0; d < 4; d++) begin
            do_write(8'h20 + 8'(d), 8'(8'h81 + d * 8'h13));
            do_write(8'h40 + 8'(d), 8'(8'h0C + d * 8'h45));
        end
        for (int d = 0; d < 4; d++) begin
            glyph_chk("R6 blink off ph0", d, 1'b0, 1'b0);
            glyph_chk("R6 blink off ph1", d, 1'b0, 1'b1);
            glyph_chk("R7 blink on ph0", d, 1'b1, 1'b0);
            glyph_chk("R7 R8 blink on ph1", d, 1'b1, 1'b1);
        end
        // R8: explicit invert case, 0xA5 -> idx 0x25, inv 1
        do_write(8'h22, 8'hA5);
        scan_digit = 2'd2;
        blink_en = 1'b0;
        #1;
        chk("R8 idx", {1'b0, glyph_idx}, 8'h25);
        chk("R8 inv", {7'b0, glyph_inv}, 8'h01);

        // R9: clear alone
        @(negedge clk);
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            m0[k] = 8'h20;
            m1[k] = 8'h20;
        end
        #1;
        check_all_storage("R9 clear");
        // R9: clear beats a simultaneous write
        do_write(8'h61, 8'h77);
        @(negedge clk);
        clear_req = 1'b1;
        wr_en = 1'b1;
        wr_addr = 8'h41;
        wr_data = 8'h99;
        @(negedge clk);
        clear_req = 1'b0;
        wr_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            m0[k] = 8'h20;
            m1[k] = 8'h20;
        end
        #1;
        check_all_storage("R9 clear over write");
        for (int d = 0; d < 4; d++) glyph_chk("R9 scan blank", d, 1'b1, 1'b1);

        finish_run();
    end
endmodule